// File: doc/BRIEF.md
# Link Master Control Register

This block holds the eight-bit control word of a serial position-encoder link master and turns its bits into control actions. Software reaches it over a simple register bus. The control word sits at address 0x0. The pipeline status register sits at 0x4 and the pipeline data register at 0x5.

Three bits hold the protocol engine, the message channel and the pipeline FIFO in reset. Clearing the protocol bit also fires a one-cycle restart pulse. One bit selects which edge of the external sync input counts as a sync event. Another chooses whether position-ready is raised for every received position frame or only for the first frame after a sync event. A further bit moves pipeline access from the direct registers to a streaming SPI port. The last active bit enables the line driver. A test bit is stored and read back and has no other effect.

The protocol engine, FIFO storage and SPI transport are outside this block. They appear only as plain request, strobe and status signals.

Top module: `link_ctrl_top`

## Requirements
- R1: After a synchronous active-low reset, the control word reads 0x00 and every control output is low: proto_rst_o, restart_o, msg_rst_o, fifo_rst_o, spi_en_o, line_oe_o, pos_ready_o and fifo_wr_o.
- R2: A bus write to address 0x0 stores all eight bits and a read returns them. The bit meanings are: bit 7 protocol hold, bit 6 message hold, bit 5 FIFO hold, bit 4 test bit, bit 3 ready-on-every-frame, bit 2 SPI routing, bit 1 sync falling edge, bit 0 line enable. The control word changes on no other cycle except reset.
- R3: proto_rst_o equals bit 7. restart_o is high for exactly the one cycle after the write that clears bit 7, and it stays low while bit 7 is set.
- R4: msg_rst_o equals bit 6.
- R5: While bit 5 is set, fifo_rst_o is high and fifo_wr_o stays low whatever fifo_wr_i does. A read of the data register returns 0 and does not assert pipe_pop_o.
- R6: Bit 4 is stored and read back and changes no output.
- R7: With bit 1 at 0, a rising edge of sync_i is a sync event. With bit 1 at 1, a falling edge is the sync event. The other edge is ignored.
- R8: With bit 3 at 1, pos_ready_o pulses for one cycle, one cycle after every pos_frame_i strobe. With bit 3 at 0, it pulses only for a strobe that follows a sync event.
- R9: While bit 2 is set, the status and data registers read 0, spi_en_o is high and pipe_pop_o stays low. While bit 2 is clear, the reads return pipe_stat_i and pipe_data_i, and a data read asserts pipe_pop_o.
- R10: line_oe_o equals bit 0.
- R11: Reads of any address other than 0x0, 0x4 and 0x5 return 0. Writes to those addresses change nothing.
- R12: A sync event stays latched until one position frame consumes it. A second frame with no new sync event produces no pulse when bit 3 is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low master reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational during a read |
| pipe_stat_i | input | 8 | Live pipeline status |
| pipe_data_i | input | 8 | Head of pipeline FIFO |
| pipe_pop_o | output | 1 | Pops the FIFO on a direct data read |
| fifo_wr_i | input | 1 | FIFO write request from the receiver |
| fifo_wr_o | output | 1 | Write request passed to FIFO storage |
| fifo_rst_o | output | 1 | FIFO hold-in-reset |
| proto_rst_o | output | 1 | Protocol engine hold-in-reset |
| restart_o | output | 1 | One-cycle connection restart |
| msg_rst_o | output | 1 | Message channel hold-in-reset |
| spi_en_o | output | 1 | Pipeline routed to SPI stream |
| line_oe_o | output | 1 | Line driver enable |
| sync_i | input | 1 | Asynchronous sync input |
| pos_frame_i | input | 1 | One-cycle strobe per received position frame |
| pos_ready_o | output | 1 | Qualified position-ready pulse |

## Verification
The assertions watch these properties on every cycle: the control word stays stable outside address-0x0 writes, restart_o is a single pulse that coincides with bit 7 being cleared, FIFO writes are held off during FIFO hold, SPI routing blocks direct pops, and position-ready occurs only after a frame strobe. Some behaviour can be shown only by the bench's scenarios. These are the edge polarity choice through the synchronizer, the latching of one sync event for exactly one frame, the two ready modes, the read-back values of the pipeline registers, and the handling of unmapped addresses.

// File: rtl/lmc_pkg.sv
// Shared types for the link master control block.
// Assumes the control word is exactly eight bits wide, most significant field first.
package lmc_pkg;

    // Control word layout; bit 7 is the first field
    typedef struct packed {
        logic proto_hold;   // bit 7
        logic msg_hold;     // bit 6
        logic fifo_hold;    // bit 5
        logic test_bit;     // bit 4
        logic ready_all;    // bit 3
        logic spi_route;    // bit 2
        logic sync_fall;    // bit 1
        logic line_en;      // bit 0
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

endpackage

// File: rtl/lmc_ctrl_regs.sv
// Register file: stores the control word and serves bus reads.
// Assumes a single-cycle bus with combinational read data.
// Pipeline registers are gated by the SPI routing and FIFO hold bits.
module lmc_ctrl_regs
    import lmc_pkg::*;
#(
    parameter int ADDR_W    = 4,
    parameter int DATA_W    = 8,
    parameter int CTRL_ADDR = 0,
    parameter int STAT_ADDR = 4,
    parameter int DATA_ADDR = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [DATA_W-1:0] pipe_stat_i,
    input  logic [DATA_W-1:0] pipe_data_i,
    output logic              pipe_pop_o,
    output ctrl_t             ctrl_o
);

    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(CTRL_ADDR);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(STAT_ADDR);
    localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(DATA_ADDR);

    ctrl_t ctrl_q;
    logic  rd_en;
    logic  pipe_block;

    assign rd_en      = bus_sel && !bus_wr;
    assign pipe_block = ctrl_q.spi_route || ctrl_q.fifo_hold;

    // Control word update: only bus writes to the control address, cleared by reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (bus_sel && bus_wr && bus_addr == A_CTRL) begin
            ctrl_q <= ctrl_t'(bus_wdata[CTRL_W-1:0]);
        end
    end

    // Read mux: unmapped addresses and blocked pipeline registers return zero
    always_comb begin
        bus_rdata = '0;
        if (rd_en) begin
            unique case (bus_addr)
                A_CTRL:  bus_rdata = DATA_W'(ctrl_q);
                A_STAT:  bus_rdata = pipe_block ? '0 : pipe_stat_i;
                A_DATA:  bus_rdata = pipe_block ? '0 : pipe_data_i;
                default: bus_rdata = '0;
            endcase
        end
    end

    // Pop request: a direct data read consumes one FIFO entry
    always_comb begin
        pipe_pop_o = rd_en && (bus_addr == A_DATA) && !pipe_block;
    end

    assign ctrl_o = ctrl_q;

endmodule

// File: rtl/lmc_reset_ctl.sv
// Reset and enable outputs derived from the control word.
// Issues a one-cycle restart when the protocol hold bit falls.
// Assumes the control word comes from flops, so the outputs are glitch-free.
module lmc_reset_ctl
    import lmc_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  ctrl_t ctrl_i,
    input  logic  fifo_wr_i,
    output logic  fifo_wr_o,
    output logic  fifo_rst_o,
    output logic  proto_rst_o,
    output logic  restart_o,
    output logic  msg_rst_o,
    output logic  spi_en_o,
    output logic  line_oe_o
);

    logic proto_prev_q;

    // Remember last cycle's protocol hold to find its falling edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            proto_prev_q <= 1'b0;
        end else begin
            proto_prev_q <= ctrl_i.proto_hold;
        end
    end

    // Level outputs and the restart edge
    always_comb begin
        proto_rst_o = ctrl_i.proto_hold;
        restart_o   = proto_prev_q && !ctrl_i.proto_hold;
        msg_rst_o   = ctrl_i.msg_hold;
        fifo_rst_o  = ctrl_i.fifo_hold;
        fifo_wr_o   = fifo_wr_i && !ctrl_i.fifo_hold;
        spi_en_o    = ctrl_i.spi_route;
        line_oe_o   = ctrl_i.line_en;
    end

endmodule

// File: rtl/lmc_pos_qual.sv
// Sync edge detection and position-ready qualification.
// sync_i is asynchronous and passes through a SYNC_STAGES flop synchronizer.
// pos_frame_i is a one-cycle strobe in the clk domain.
module lmc_pos_qual #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sync_i,
    input  logic sel_fall_i,
    input  logic ready_all_i,
    input  logic pos_frame_i,
    output logic pos_ready_o
);

    logic [SYNC_STAGES:0] sync_chain;
    logic                 sync_prev_q;
    logic                 sync_now;
    logic                 rise_det;
    logic                 fall_det;
    logic                 sync_evt;
    logic                 pend_q;
    logic                 ready_q;

    assign sync_chain[0] = sync_i;

    // Synchronizer stages built from the stage count
    for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
        // Shift one stage toward the clk domain
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                sync_chain[g+1] <= 1'b0;
            end else begin
                sync_chain[g+1] <= sync_chain[g];
            end
        end
    end

    assign sync_now = sync_chain[SYNC_STAGES];

    // Previous synchronized level for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_prev_q <= 1'b0;
        end else begin
            sync_prev_q <= sync_now;
        end
    end

    // Edge selection by the polarity bit
    always_comb begin
        rise_det = sync_now && !sync_prev_q;
        fall_det = !sync_now && sync_prev_q;
        sync_evt = sel_fall_i ? fall_det : rise_det;
    end

    // Pending sync event, consumed by the next position frame
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
        end else begin
            pend_q <= (pend_q || sync_evt) && !pos_frame_i;
        end
    end

    // Registered ready pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ready_q <= 1'b0;
        end else begin
            ready_q <= pos_frame_i && (ready_all_i || pend_q || sync_evt);
        end
    end

    assign pos_ready_o = ready_q;

endmodule

// File: rtl/link_ctrl_top.sv
// Link master control register top level.
// Wires the register file, reset control and position qualifier together.
// Assumes a single clock domain except for sync_i.
module link_ctrl_top
    import lmc_pkg::*;
#(
    parameter int ADDR_W      = 4,
    parameter int DATA_W      = 8,
    parameter int CTRL_ADDR   = 0,
    parameter int STAT_ADDR   = 4,
    parameter int DATA_ADDR   = 5,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [DATA_W-1:0] pipe_stat_i,
    input  logic [DATA_W-1:0] pipe_data_i,
    output logic              pipe_pop_o,
    input  logic              fifo_wr_i,
    output logic              fifo_wr_o,
    output logic              fifo_rst_o,
    output logic              proto_rst_o,
    output logic              restart_o,
    output logic              msg_rst_o,
    output logic              spi_en_o,
    output logic              line_oe_o,
    input  logic              sync_i,
    input  logic              pos_frame_i,
    output logic              pos_ready_o
);

    ctrl_t ctrl_w;

    lmc_ctrl_regs #(
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W),
        .CTRL_ADDR (CTRL_ADDR),
        .STAT_ADDR (STAT_ADDR),
        .DATA_ADDR (DATA_ADDR)
    ) regs_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_sel     (bus_sel),
        .bus_wr      (bus_wr),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .bus_rdata   (bus_rdata),
        .pipe_stat_i (pipe_stat_i),
        .pipe_data_i (pipe_data_i),
        .pipe_pop_o  (pipe_pop_o),
        .ctrl_o      (ctrl_w)
    );

    lmc_reset_ctl rst_ctl_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .ctrl_i      (ctrl_w),
        .fifo_wr_i   (fifo_wr_i),
        .fifo_wr_o   (fifo_wr_o),
        .fifo_rst_o  (fifo_rst_o),
        .proto_rst_o (proto_rst_o),
        .restart_o   (restart_o),
        .msg_rst_o   (msg_rst_o),
        .spi_en_o    (spi_en_o),
        .line_oe_o   (line_oe_o)
    );

    lmc_pos_qual #(
        .SYNC_STAGES (SYNC_STAGES)
    ) qual_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .sync_i      (sync_i),
        .sel_fall_i  (ctrl_w.sync_fall),
        .ready_all_i (ctrl_w.ready_all),
        .pos_frame_i (pos_frame_i),
        .pos_ready_o (pos_ready_o)
    );

endmodule

// File: rtl/link_ctrl_chk.sv
// Checker for link_ctrl_top, attached by bind. It observes the block and drives nothing.
module link_ctrl_chk #(
    parameter int ADDR_W    = 4,
    parameter int DATA_W    = 8,
    parameter int CTRL_ADDR = 0,
    parameter int STAT_ADDR = 4,
    parameter int DATA_ADDR = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_rdata,
    input logic [DATA_W-1:0] ctrl_word,
    input logic              pipe_pop_o,
    input logic              fifo_wr_o,
    input logic              fifo_rst_o,
    input logic              proto_rst_o,
    input logic              restart_o,
    input logic              spi_en_o,
    input logic              pos_frame_i,
    input logic              pos_ready_o
);

    // Control word changes only on a control-address write (R2)
    p_ctrl_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_sel && bus_wr && bus_addr == ADDR_W'(CTRL_ADDR)) |=> $stable(ctrl_word));

    // Restart is a single-cycle pulse (R3)
    p_restart_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        restart_o |=> !restart_o);

    // Restart only when protocol hold has just dropped (R3)
    p_restart_on_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        restart_o |-> (!proto_rst_o && $past(proto_rst_o)));

    // FIFO writes are held off during FIFO hold (R5)
    p_fifo_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_rst_o |-> !fifo_wr_o);

    // SPI routing blocks direct pops and pipeline read-back (R9)
    p_spi_blocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_en_o && bus_sel && !bus_wr &&
         (bus_addr == ADDR_W'(STAT_ADDR) || bus_addr == ADDR_W'(DATA_ADDR)))
        |-> (!pipe_pop_o && bus_rdata == '0));

    // Ready pulse always follows a frame strobe (R8)
    p_ready_after_frame_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pos_ready_o) |-> $past(pos_frame_i));

endmodule

bind link_ctrl_top link_ctrl_chk #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .CTRL_ADDR (CTRL_ADDR),
    .STAT_ADDR (STAT_ADDR),
    .DATA_ADDR (DATA_ADDR)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_sel     (bus_sel),
    .bus_wr      (bus_wr),
    .bus_addr    (bus_addr),
    .bus_rdata   (bus_rdata),
    .ctrl_word   (DATA_W'(ctrl_w)),
    .pipe_pop_o  (pipe_pop_o),
    .fifo_wr_o   (fifo_wr_o),
    .fifo_rst_o  (fifo_rst_o),
    .proto_rst_o (proto_rst_o),
    .restart_o   (restart_o),
    .spi_en_o    (spi_en_o),
    .pos_frame_i (pos_frame_i),
    .pos_ready_o (pos_ready_o)
);

// File: tb/link_ctrl_top_tb_top.sv
// Directed bench for link_ctrl_top: one task per scenario.
module link_ctrl_top_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_sel = 1'b0;
    logic       bus_wr = 1'b0;
    logic [3:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [7:0] pipe_stat_i = 8'hA5;
    logic [7:0] pipe_data_i = 8'h3C;
    logic       pipe_pop_o;
    logic       fifo_wr_i = 1'b0;
    logic       fifo_wr_o;
    logic       fifo_rst_o;
    logic       proto_rst_o;
    logic       restart_o;
    logic       msg_rst_o;
    logic       spi_en_o;
    logic       line_oe_o;
    logic       sync_i = 1'b0;
    logic       pos_frame_i = 1'b0;
    logic       pos_ready_o;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;

    link_ctrl_top dut_i (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pipe_stat_i(pipe_stat_i), .pipe_data_i(pipe_data_i), .pipe_pop_o(pipe_pop_o),
        .fifo_wr_i(fifo_wr_i), .fifo_wr_o(fifo_wr_o), .fifo_rst_o(fifo_rst_o),
        .proto_rst_o(proto_rst_o), .restart_o(restart_o), .msg_rst_o(msg_rst_o),
        .spi_en_o(spi_en_o), .line_oe_o(line_oe_o), .sync_i(sync_i),
        .pos_frame_i(pos_frame_i), .pos_ready_o(pos_ready_o)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    // Write lands at the posedge between two negedges
    task automatic bus_write(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    // Combinational read sampled mid-cycle, pop flag returned as well
    task automatic bus_read(input logic [3:0] a, output logic [7:0] d, output logic pop);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1;
        d = bus_rdata; pop = pipe_pop_o;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    // One frame strobe; the ready pulse is visible at the following negedge
    task automatic frame(output logic rdy);
        @(negedge clk);
        pos_frame_i = 1'b1;
        @(negedge clk);
        pos_frame_i = 1'b0;
        rdy = pos_ready_o;
    endtask

    task automatic set_sync(input logic v);
        @(negedge clk);
        sync_i = v;
        repeat (4) @(negedge clk);
    endtask

    function automatic logic [7:0] outs();
        return {proto_rst_o, restart_o, msg_rst_o, fifo_rst_o,
                spi_en_o, line_oe_o, pos_ready_o, fifo_wr_o};
    endfunction

    task automatic t_reset();
        logic [7:0] d; logic p;
        check("R1 outputs", outs(), 8'h00);
        bus_read(4'h0, d, p);
        check("R1 ctrl", d, 8'h00);
    endtask

    task automatic t_rw();
        logic [7:0] d; logic p;
        bus_write(4'h0, 8'h5A);
        bus_read(4'h0, d, p);
        check("R2 readback", d, 8'h5A);
        check("R4 msg", {7'd0, msg_rst_o}, 8'h01);
        check("R10 oe low", {7'd0, line_oe_o}, 8'h00);
        bus_write(4'h0, 8'h01);
        check("R10 oe high", {7'd0, line_oe_o}, 8'h01);
        check("R4 msg clear", {7'd0, msg_rst_o}, 8'h00);
        bus_write(4'h0, 8'h10);
        bus_read(4'h0, d, p);
        check("R6 readback", d, 8'h10);
        check("R6 no effect", outs(), 8'h00);
    endtask

    task automatic t_restart();
        bus_write(4'h0, 8'h80);
        check("R3 hold", {proto_rst_o, restart_o}, 8'h02);
        @(negedge clk);
        check("R3 no pulse while set", {7'd0, restart_o}, 8'h00);
        bus_write(4'h0, 8'h00);
        check("R3 pulse", {proto_rst_o, restart_o}, 8'h01);
        @(negedge clk);
        check("R3 pulse width", {7'd0, restart_o}, 8'h00);
    endtask

    task automatic t_pipe();
        logic [7:0] d; logic p;
        bus_write(4'h0, 8'h00);
        bus_read(4'h4, d, p);
        check("R9 status live", d, 8'hA5);
        bus_read(4'h5, d, p);
        check("R9 data live", {d[6:0], p}, {8'h3C} << 1 | 8'h01);
        bus_write(4'h0, 8'h04);
        check("R9 spi_en", {7'd0, spi_en_o}, 8'h01);
        bus_read(4'h4, d, p);
        check("R9 status zero", d, 8'h00);
        bus_read(4'h5, d, p);
        check("R9 data zero no pop", {d[6:0], p}, 8'h00);
        bus_write(4'h0, 8'h20);
        fifo_wr_i = 1'b1;
        #1;
        check("R5 write dropped", {fifo_rst_o, fifo_wr_o}, 8'h02);
        bus_read(4'h5, d, p);
        check("R5 data zero no pop", {d[6:0], p}, 8'h00);
        bus_write(4'h0, 8'h00);
        #1;
        check("R5 write passes", {fifo_rst_o, fifo_wr_o}, 8'h01);
        fifo_wr_i = 1'b0;
    endtask

    task automatic t_unmapped();
        logic [7:0] d; logic p;
        bus_write(4'h0, 8'h41);
        bus_write(4'h3, 8'hFF);
        bus_write(4'hF, 8'h00);
        bus_read(4'h0, d, p);
        check("R11 ctrl untouched", d, 8'h41);
        bus_read(4'h3, d, p);
        check("R11 unmapped read", d, 8'h00);
        bus_write(4'h0, 8'h00);
    endtask

    task automatic t_sync();
        logic r;
        bus_write(4'h0, 8'h00);
        frame(r); check("R8 no sync no ready", {7'd0, r}, 8'h00);
        set_sync(1'b1);
        frame(r); check("R7 rising event", {7'd0, r}, 8'h01);
        frame(r); check("R12 consumed", {7'd0, r}, 8'h00);
        set_sync(1'b0);
        frame(r); check("R7 falling ignored", {7'd0, r}, 8'h00);
        bus_write(4'h0, 8'h02);
        set_sync(1'b1);
        frame(r); check("R7 rising ignored", {7'd0, r}, 8'h00);
        set_sync(1'b0);
        repeat (3) @(negedge clk);
        frame(r); check("R12 latched falling", {7'd0, r}, 8'h01);
        frame(r); check("R12 single use", {7'd0, r}, 8'h00);
        bus_write(4'h0, 8'h08);
        frame(r); check("R8 every frame a", {7'd0, r}, 8'h01);
        frame(r); check("R8 every frame b", {7'd0, r}, 8'h01);
        @(negedge clk);
        check("R8 pulse width", {7'd0, pos_ready_o}, 8'h00);
        bus_write(4'h0, 8'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_rw();
        t_restart();
        t_pipe();
        t_unmapped();
        t_sync();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_checks++; n_fails++;
                $display("FAIL watchdog: actual hung expected done");
            end
        join_any
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule